// File: doc/BRIEF.md
# Vector move and zeroing unit

This execution unit runs a small set of already decoded vector instructions against its own bank of wide vector registers. The decoder in front of it supplies the prefix class, the opcode map, the vector length bit, the opcode byte, a flag for the register form, the effective address, and three register indices. The indices arrive resolved: `dst_i` is the register written, `src_i` the register read, and `src2_i` the second register read by the scalar merge. The unit performs packed register moves, loads and stores, scalar 64-bit double moves with lane merging, and two zeroing operations. Every register write clears the bits above the result.

Memory goes through a simple request/ready port. A load writes its register on the edge where the ready signal is seen. One instruction is in flight at a time. A combinational peek port returns the contents of any register, and it is how the register bank is read out to the rest of the datapath.

Top module: `vmz_unit`

## Requirements
- R1: After reset every register reads as zero, `issue_ready_o` is 1, and `mem_req_o`, `done_o` and `illegal_o` are 0.
- R2: Prefix codes are none=0, 66=1, F3=2, F2=3, and the 0F map is code 1. In the register form, opcodes 28h/29h (prefix none or 66), 6Fh/7Fh (prefix 66) and 10h/11h (prefix none) copy the low 128 bits of `src_i` into `dst_i`, or the low 256 bits when `vl256_i`=1. All higher bits of the destination are cleared.
- R3: The memory forms of 28h, 6Fh and 10h (same prefixes as R2) are loads. A load holds `mem_req_o`=1 with `mem_we_o`=0, `mem_addr_o` equal to the issued address and `mem_size_o` of 16 or 32 bytes until `mem_ready_i` is 1. On that edge `dst_i` takes the zero-extended low 128 or 256 bits of `mem_rdata_i`.
- R4: The memory forms of 29h, 7Fh and 11h (same prefixes) are stores. A store drives `mem_we_o`=1 and 16 or 32 bytes of `src_i`, with the unused upper data bits at zero, and changes no register.
- R5: With prefix F2, the register forms of 10h and 11h write bits 63:0 from `src_i` and bits 127:64 from `src2_i`, clear the bits above, and ignore `vl256_i`.
- R6: With prefix F2, the memory form of 10h requests 8 bytes and writes `mem_rdata_i[63:0]` into bits 63:0 of the destination with all other bits cleared.
- R7: With prefix F2, the memory form of 11h stores 8 bytes from `src_i[63:0]` with the higher data bits zero, and changes no register.
- R8: Opcode 77h with no prefix and `vl256_i`=1 clears every bit of the registers in range.
- R9: Opcode 77h with no prefix and `vl256_i`=0 clears bits 511:128 of the registers in range and keeps bits 127:0.
- R10: The zeroing range is registers 0 to 7 when `mode64_i`=0 and registers 0 to 15 when it is 1. Registers outside the range are unchanged.
- R11: Any other combination of prefix, map and opcode, and any used register index of 8 or more while `mode64_i`=0, pulses `illegal_o` in the cycle after issue. It gives no `done_o` and changes no register.
- R12: `done_o` pulses in the cycle after a register-only instruction is issued, and in the cycle after the memory handshake completes. `issue_ready_o` is 0 while a memory request is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| issue_valid_i | input | 1 | Decoded instruction present |
| issue_ready_o | output | 1 | Unit idle, instruction accepted |
| pfx_i | input | 2 | Mandatory prefix class |
| map_i | input | 2 | Opcode map |
| opc_i | input | 8 | Opcode byte |
| vl256_i | input | 1 | Vector length: 1 = 256 bits, 0 = 128 bits |
| reg_form_i | input | 1 | Register operand form (1) or memory form (0) |
| mode64_i | input | 1 | 64-bit mode, widens register range |
| dst_i | input | 4 | Destination register index |
| src_i | input | 4 | Source register index |
| src2_i | input | 4 | Second source register index |
| addr_i | input | 32 | Effective memory address |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Memory write |
| mem_addr_o | output | 32 | Memory address |
| mem_size_o | output | 6 | Access size in bytes |
| mem_wdata_o | output | 256 | Store data |
| mem_ready_i | input | 1 | Memory handshake complete |
| mem_rdata_i | input | 256 | Load data |
| done_o | output | 1 | Instruction completed |
| illegal_o | output | 1 | Unsupported encoding |
| peek_idx_i | input | 4 | Register peek index |
| peek_data_o | output | 512 | Register peek data |

## Verification
The bench builds the unit with its defaults: 512-bit registers, 16 registers in total and 8 outside 64-bit mode. That puts the split between the legacy and the extended register range within reach, both for the zeroing span and for the index check that flags an encoding illegal. Loads fill registers with up to 256 random bits, so the clearing of bits 511:256 and 511:128 is observed through the peek port on data that really had set bits below. Random memory latencies of zero to three cycles test the request hold and the timing of completion.

// File: rtl/vmz_pkg.sv
package vmz_pkg;
  localparam int LANE_W = 64;
  localparam int XMM_W  = 128;
  localparam int YMM_W  = 256;

  localparam logic [1:0] PFX_NONE = 2'd0;
  localparam logic [1:0] PFX_66   = 2'd1;
  localparam logic [1:0] PFX_F3   = 2'd2;
  localparam logic [1:0] PFX_F2   = 2'd3;
  localparam logic [1:0] MAP_0F   = 2'd1;

  typedef enum logic [3:0] {
    K_ILL, K_MOV, K_LD, K_ST, K_SD_MOV, K_SD_LD, K_SD_ST, K_ZALL, K_ZUP
  } op_kind_e;

  typedef enum logic {ST_IDLE, ST_MEM} state_e;
endpackage

// File: rtl/vmz_decode.sv
module vmz_decode
  import vmz_pkg::*;
#(
  parameter int IDX_W       = 4,
  parameter int NUM_REG     = 16,
  parameter int LEGACY_REGS = 8
) (
  input  logic [1:0]       pfx_i,
  input  logic [1:0]       map_i,
  input  logic [7:0]       opc_i,
  input  logic             vl256_i,
  input  logic             reg_form_i,
  input  logic             mode64_i,
  input  logic [IDX_W-1:0] dst_i,
  input  logic [IDX_W-1:0] src_i,
  input  logic [IDX_W-1:0] src2_i,
  output op_kind_e         kind_o,
  output logic [IDX_W:0]   lim_o
);
  op_kind_e base;
  logic use_dst, use_src, use_src2, bad_idx;

  always_comb begin
    base = K_ILL;
    if (map_i == MAP_0F) begin
      unique case (opc_i)
        8'h28: if (pfx_i == PFX_NONE || pfx_i == PFX_66) base = reg_form_i ? K_MOV : K_LD;
        8'h29: if (pfx_i == PFX_NONE || pfx_i == PFX_66) base = reg_form_i ? K_MOV : K_ST;
        8'h6F: if (pfx_i == PFX_66) base = reg_form_i ? K_MOV : K_LD;
        8'h7F: if (pfx_i == PFX_66) base = reg_form_i ? K_MOV : K_ST;
        8'h10: begin
          if (pfx_i == PFX_NONE)    base = reg_form_i ? K_MOV : K_LD;
          else if (pfx_i == PFX_F2) base = reg_form_i ? K_SD_MOV : K_SD_LD;
        end
        8'h11: begin
          if (pfx_i == PFX_NONE)    base = reg_form_i ? K_MOV : K_ST;
          else if (pfx_i == PFX_F2) base = reg_form_i ? K_SD_MOV : K_SD_ST;
        end
        8'h77: if (pfx_i == PFX_NONE) base = vl256_i ? K_ZALL : K_ZUP;
        default: base = K_ILL;
      endcase
    end
  end

  assign lim_o    = mode64_i ? (IDX_W+1)'(NUM_REG) : (IDX_W+1)'(LEGACY_REGS);
  assign use_dst  = base inside {K_MOV, K_LD, K_SD_MOV, K_SD_LD};
  assign use_src  = base inside {K_MOV, K_ST, K_SD_MOV, K_SD_ST};
  assign use_src2 = (base == K_SD_MOV);
  assign bad_idx  = (use_dst  && {1'b0, dst_i}  >= lim_o) ||
                    (use_src  && {1'b0, src_i}  >= lim_o) ||
                    (use_src2 && {1'b0, src2_i} >= lim_o);
  assign kind_o   = bad_idx ? K_ILL : base;
endmodule

// File: rtl/vmz_regfile.sv
module vmz_regfile
  import vmz_pkg::*;
#(
  parameter int VREG_W  = 512,
  parameter int NUM_REG = 16,
  parameter int IDX_W   = $clog2(NUM_REG)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  widx_i,
  input  logic [VREG_W-1:0] wdata_i,
  input  logic              zall_i,
  input  logic              zup_i,
  input  logic [IDX_W:0]    zlim_i,
  input  logic [IDX_W-1:0]  ra_idx_i,
  input  logic [IDX_W-1:0]  rb_idx_i,
  input  logic [IDX_W-1:0]  rc_idx_i,
  output logic [VREG_W-1:0] ra_o,
  output logic [VREG_W-1:0] rb_o,
  output logic [VREG_W-1:0] rc_o
);
  logic [VREG_W-1:0] regs [NUM_REG];

  for (genvar i = 0; i < NUM_REG; i++) begin : g_reg
    logic [VREG_W-1:0] q;
    logic in_zone;
    assign in_zone = (IDX_W+1)'(i) < zlim_i;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        q <= '0;
      end else if (zall_i && in_zone) begin
        q <= '0;
      end else if (zup_i && in_zone) begin
        q[VREG_W-1:XMM_W] <= '0;
      end else if (we_i && widx_i == IDX_W'(i)) begin
        q <= wdata_i;
      end
    end
    assign regs[i] = q;
  end

  assign ra_o = regs[ra_idx_i];
  assign rb_o = regs[rb_idx_i];
  assign rc_o = regs[rc_idx_i];
endmodule

// File: rtl/vmz_format.sv
module vmz_format
  import vmz_pkg::*;
#(
  parameter int VREG_W = 512,
  parameter int SIZE_W = 6
) (
  input  op_kind_e          kind_i,
  input  logic              vl256_i,
  input  logic [YMM_W-1:0]  a_i,
  input  logic [XMM_W-1:0]  b_i,
  input  logic [YMM_W-1:0]  mem_i,
  output logic [VREG_W-1:0] reg_o,
  output logic [YMM_W-1:0]  st_o,
  output logic [SIZE_W-1:0] size_o
);
  always_comb begin
    reg_o = '0;
    unique case (kind_i)
      K_MOV:    if (vl256_i) reg_o[YMM_W-1:0] = a_i; else reg_o[XMM_W-1:0] = a_i[XMM_W-1:0];
      K_LD:     if (vl256_i) reg_o[YMM_W-1:0] = mem_i; else reg_o[XMM_W-1:0] = mem_i[XMM_W-1:0];
      K_SD_MOV: reg_o[XMM_W-1:0] = {b_i[XMM_W-1:LANE_W], a_i[LANE_W-1:0]};
      K_SD_LD:  reg_o[LANE_W-1:0] = mem_i[LANE_W-1:0];
      default:  reg_o = '0;
    endcase
  end

  always_comb begin
    st_o = '0;
    unique case (kind_i)
      K_ST:    if (vl256_i) st_o = a_i; else st_o[XMM_W-1:0] = a_i[XMM_W-1:0];
      K_SD_ST: st_o[LANE_W-1:0] = a_i[LANE_W-1:0];
      default: st_o = '0;
    endcase
  end

  always_comb begin
    if (kind_i inside {K_SD_LD, K_SD_ST, K_SD_MOV}) size_o = SIZE_W'(LANE_W / 8);
    else if (vl256_i)                               size_o = SIZE_W'(YMM_W / 8);
    else                                            size_o = SIZE_W'(XMM_W / 8);
  end
endmodule

// File: rtl/vmz_unit.sv
module vmz_unit
  import vmz_pkg::*;
#(
  parameter int VREG_W      = 512,
  parameter int NUM_REG     = 16,
  parameter int LEGACY_REGS = 8,
  parameter int ADDR_W      = 32,
  localparam int IDX_W      = $clog2(NUM_REG),
  localparam int SIZE_W     = $clog2(YMM_W / 8) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              issue_valid_i,
  output logic              issue_ready_o,
  input  logic [1:0]        pfx_i,
  input  logic [1:0]        map_i,
  input  logic [7:0]        opc_i,
  input  logic              vl256_i,
  input  logic              reg_form_i,
  input  logic              mode64_i,
  input  logic [IDX_W-1:0]  dst_i,
  input  logic [IDX_W-1:0]  src_i,
  input  logic [IDX_W-1:0]  src2_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [SIZE_W-1:0] mem_size_o,
  output logic [YMM_W-1:0]  mem_wdata_o,
  input  logic              mem_ready_i,
  input  logic [YMM_W-1:0]  mem_rdata_i,
  output logic              done_o,
  output logic              illegal_o,
  input  logic [IDX_W-1:0]  peek_idx_i,
  output logic [VREG_W-1:0] peek_data_o
);
  state_e            st_q;
  op_kind_e          kind_d, kind_q, kind_act;
  logic [IDX_W:0]    lim;
  logic              vl_q, vl_act, done_q, ill_q;
  logic [IDX_W-1:0]  dst_q, widx;
  logic [ADDR_W-1:0] addr_q;
  logic [YMM_W-1:0]  st_data_q, fmt_st;
  logic [SIZE_W-1:0] size_q, fmt_size;
  logic [VREG_W-1:0] ra, rb, fmt_reg;
  logic              fire, mem_done, is_mem_d, we, zall, zup;
  logic              unused_bits;

  vmz_decode #(.IDX_W(IDX_W), .NUM_REG(NUM_REG), .LEGACY_REGS(LEGACY_REGS)) u_dec (
    .pfx_i, .map_i, .opc_i, .vl256_i, .reg_form_i, .mode64_i,
    .dst_i, .src_i, .src2_i, .kind_o(kind_d), .lim_o(lim)
  );

  assign fire     = issue_valid_i && (st_q == ST_IDLE);
  assign mem_done = (st_q == ST_MEM) && mem_ready_i;
  assign is_mem_d = kind_d inside {K_LD, K_ST, K_SD_LD, K_SD_ST};
  assign kind_act = (st_q == ST_MEM) ? kind_q : kind_d;
  assign vl_act   = (st_q == ST_MEM) ? vl_q : vl256_i;

  vmz_format #(.VREG_W(VREG_W), .SIZE_W(SIZE_W)) u_fmt (
    .kind_i(kind_act), .vl256_i(vl_act),
    .a_i(ra[YMM_W-1:0]), .b_i(rb[XMM_W-1:0]), .mem_i(mem_rdata_i),
    .reg_o(fmt_reg), .st_o(fmt_st), .size_o(fmt_size)
  );

  assign we   = (fire && kind_d inside {K_MOV, K_SD_MOV}) ||
                (mem_done && kind_q inside {K_LD, K_SD_LD});
  assign widx = (st_q == ST_MEM) ? dst_q : dst_i;
  assign zall = fire && (kind_d == K_ZALL);
  assign zup  = fire && (kind_d == K_ZUP);

  vmz_regfile #(.VREG_W(VREG_W), .NUM_REG(NUM_REG), .IDX_W(IDX_W)) u_rf (
    .clk_i, .rst_ni, .we_i(we), .widx_i(widx), .wdata_i(fmt_reg),
    .zall_i(zall), .zup_i(zup), .zlim_i(lim),
    .ra_idx_i(src_i), .rb_idx_i(src2_i), .rc_idx_i(peek_idx_i),
    .ra_o(ra), .rb_o(rb), .rc_o(peek_data_o)
  );

  assign unused_bits = ^{ra[VREG_W-1:YMM_W], rb[VREG_W-1:XMM_W]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      kind_q    <= K_ILL;
      vl_q      <= 1'b0;
      dst_q     <= '0;
      addr_q    <= '0;
      st_data_q <= '0;
      size_q    <= '0;
      done_q    <= 1'b0;
      ill_q     <= 1'b0;
    end else begin
      done_q <= (fire && kind_d inside {K_MOV, K_SD_MOV, K_ZALL, K_ZUP}) || mem_done;
      ill_q  <= fire && (kind_d == K_ILL);
      if (fire && is_mem_d) begin
        st_q      <= ST_MEM;
        kind_q    <= kind_d;
        vl_q      <= vl256_i;
        dst_q     <= dst_i;
        addr_q    <= addr_i;
        st_data_q <= fmt_st;
        size_q    <= fmt_size;
      end else if (mem_done) begin
        st_q <= ST_IDLE;
      end
    end
  end

  assign issue_ready_o = (st_q == ST_IDLE);
  assign mem_req_o     = (st_q == ST_MEM);
  assign mem_we_o      = mem_req_o && (kind_q inside {K_ST, K_SD_ST});
  assign mem_addr_o    = addr_q;
  assign mem_size_o    = size_q;
  assign mem_wdata_o   = st_data_q;
  assign done_o        = done_q;
  assign illegal_o     = ill_q;
endmodule

// File: rtl/vmz_unit_chk.sv
module vmz_unit_chk #(
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              issue_ready_o,
  input logic              mem_req_o,
  input logic              mem_ready_i,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [SIZE_W-1:0] mem_size_o,
  input logic              done_o,
  input logic              illegal_o
);
  assert_req_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ready_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_size_o));

  assert_mem_done_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_ready_i |=> done_o && !mem_req_o);

  assert_busy_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !issue_ready_o);

  assert_size_legal_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (mem_size_o == SIZE_W'(8) || mem_size_o == SIZE_W'(16) || mem_size_o == SIZE_W'(32)));

  assert_ill_no_done_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(illegal_o && done_o));

  assert_ill_idle_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> !mem_req_o && issue_ready_o);
endmodule

bind vmz_unit vmz_unit_chk #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .issue_ready_o(issue_ready_o),
  .mem_req_o(mem_req_o), .mem_ready_i(mem_ready_i), .mem_addr_o(mem_addr_o),
  .mem_size_o(mem_size_o), .done_o(done_o), .illegal_o(illegal_o)
);

// File: tb/vmz_unit_tb_top.sv
`timescale 1ns/100ps
module vmz_unit_tb_top;
  localparam int VW = 512;
  localparam int NR = 16;
  localparam int KI = 0, KM = 1, KL = 2, KS = 3, KSM = 4, KSL = 5, KSS = 6, KZA = 7, KZU = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic         issue_valid = 0, issue_ready;
  logic [1:0]   pfx = 0, mp = 0;
  logic [7:0]   opc = 0;
  logic         vl = 0, rf = 0, m64 = 0;
  logic [3:0]   dst = 0, src = 0, src2 = 0, peek_idx = 0;
  logic [31:0]  addr = 0, mem_addr;
  logic         mem_req, mem_we, mem_ready = 0, done, illegal;
  logic [5:0]   mem_size;
  logic [255:0] mem_wdata, mem_rdata = 0;
  logic [VW-1:0] peek_data;

  vmz_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .issue_valid_i(issue_valid), .issue_ready_o(issue_ready),
    .pfx_i(pfx), .map_i(mp), .opc_i(opc), .vl256_i(vl), .reg_form_i(rf), .mode64_i(m64),
    .dst_i(dst), .src_i(src), .src2_i(src2), .addr_i(addr),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_size_o(mem_size),
    .mem_wdata_o(mem_wdata), .mem_ready_i(mem_ready), .mem_rdata_i(mem_rdata),
    .done_o(done), .illegal_o(illegal), .peek_idx_i(peek_idx), .peek_data_o(peek_data)
  );

  int n_checks = 0, n_err = 0;
  logic [VW-1:0] model [NR];

  task automatic check(input bit ok, input string req, input string what,
                       input logic [VW-1:0] act, input logic [VW-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    bit ok = 1;
    logic [VW-1:0] a = '0, e = '0;
    for (int i = 0; i < NR; i++) begin
      peek_idx = 4'(i);
      #0.1;
      if (ok && peek_data !== model[i]) begin
        ok = 0; a = peek_data; e = model[i];
      end
    end
    check(ok, req, "register bank", a, e);
  endtask

  function automatic int classify(bit [1:0] p, bit [1:0] m, bit [7:0] o, bit r, bit v,
                                  int d, int s, int s2, bit x64);
    int k = KI;
    int lim = x64 ? 16 : 8;
    if (m == 2'd1) begin
      if ((o == 8'h28 || o == 8'h10) && p == 0) k = r ? KM : KL;
      if ((o == 8'h29 || o == 8'h11) && p == 0) k = r ? KM : KS;
      if ((o == 8'h28 || o == 8'h6F) && p == 1) k = r ? KM : KL;
      if ((o == 8'h29 || o == 8'h7F) && p == 1) k = r ? KM : KS;
      if (o == 8'h10 && p == 3) k = r ? KSM : KSL;
      if (o == 8'h11 && p == 3) k = r ? KSM : KSS;
      if (o == 8'h77 && p == 0) k = v ? KZA : KZU;
    end
    if (k inside {KM, KL, KSM, KSL} && d >= lim) k = KI;
    if (k inside {KM, KS, KSM, KSS} && s >= lim) k = KI;
    if (k == KSM && s2 >= lim) k = KI;
    return k;
  endfunction

  function automatic string tag_of(int k);
    case (k)
      KM: return "R2"; KL: return "R3"; KS: return "R4"; KSM: return "R5";
      KSL: return "R6"; KSS: return "R7"; KZA: return "R8/R10"; KZU: return "R9/R10";
      default: return "R11";
    endcase
  endfunction

  task automatic run(input bit [1:0] p, input bit [1:0] m, input bit [7:0] o, input bit r,
                     input bit v, input bit x64, input int d, input int s, input int s2,
                     input logic [255:0] rdata, input int delay);
    int k = classify(p, m, o, r, v, d, s, s2, x64);
    string t = tag_of(k);
    logic [VW-1:0] sv = model[s], s2v = model[s2], nv = '0;
    logic [255:0] exp_wd = '0;
    logic [31:0] a = $urandom;
    int lim = x64 ? 16 : 8;
    check(issue_ready === 1'b1, "R12", "ready before issue", VW'(issue_ready), VW'(1));
    pfx = p; mp = m; opc = o; rf = r; vl = v; m64 = x64;
    dst = 4'(d); src = 4'(s); src2 = 4'(s2); addr = a; issue_valid = 1;
    @(posedge clk); @(negedge clk);
    issue_valid = 0;
    if (k == KI) begin
      check(illegal === 1'b1 && done === 1'b0, "R11", "illegal pulse",
            VW'({illegal, done}), VW'(2'b10));
    end else if (k inside {KM, KSM, KZA, KZU}) begin
      check(done === 1'b1 && illegal === 1'b0, "R12", "done pulse", VW'({done, illegal}), VW'(2'b10));
      if (k == KM)  begin nv[255:0] = v ? sv[255:0] : {128'b0, sv[127:0]}; model[d] = nv; end
      if (k == KSM) begin nv[127:0] = {s2v[127:64], sv[63:0]}; model[d] = nv; end
      if (k == KZA) for (int i = 0; i < lim; i++) model[i] = '0;
      if (k == KZU) for (int i = 0; i < lim; i++) model[i][VW-1:128] = '0;
    end else begin
      int sz = (k inside {KSL, KSS}) ? 8 : (v ? 32 : 16);
      bit st = k inside {KS, KSS};
      check(mem_req === 1'b1 && mem_we === st && mem_addr === a && mem_size === 6'(sz),
            t, "request fields", VW'({mem_req, mem_we, mem_size, mem_addr}),
            VW'({1'b1, st, 6'(sz), a}));
      check(issue_ready === 1'b0, "R12", "busy during request", VW'(issue_ready), VW'(0));
      if (st) begin
        exp_wd = (k == KSS) ? {192'b0, sv[63:0]} : (v ? sv[255:0] : {128'b0, sv[127:0]});
        check(mem_wdata === exp_wd, t, "store data", VW'(mem_wdata), VW'(exp_wd));
      end
      for (int w = 0; w < delay; w++) begin
        @(posedge clk); @(negedge clk);
        check(mem_req === 1'b1 && done === 1'b0, "R3", "request held",
              VW'({mem_req, done}), VW'(2'b10));
      end
      mem_ready = 1; mem_rdata = rdata;
      @(posedge clk); @(negedge clk);
      mem_ready = 0;
      check(done === 1'b1 && mem_req === 1'b0, "R12", "done after handshake",
            VW'({done, mem_req}), VW'(2'b10));
      if (k == KL)  begin nv[255:0] = v ? rdata : {128'b0, rdata[127:0]}; model[d] = nv; end
      if (k == KSL) begin nv[63:0] = rdata[63:0]; model[d] = nv; end
    end
    check_all(t);
  endtask

  function automatic logic [255:0] rnd256();
    logic [255:0] r;
    for (int i = 0; i < 8; i++) r[i*32 +: 32] = $urandom;
    return r;
  endfunction

  initial begin
    #(5.0 * 150000);
    n_checks++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    bit [7:0] opcs [8] = '{8'h10, 8'h11, 8'h28, 8'h29, 8'h6F, 8'h7F, 8'h77, 8'h00};
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < NR; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check(issue_ready === 1'b1 && mem_req === 1'b0 && done === 1'b0 && illegal === 1'b0,
          "R1", "reset outputs", VW'({issue_ready, mem_req, done, illegal}), VW'(4'b1000));
    check_all("R1");

    // fill all registers with 256-bit loads
    for (int i = 0; i < NR; i++) run(1, 1, 8'h28, 0, 1, 1, i, 0, 0, rnd256(), i % 4);
    // R9/R10: zero-upper outside 64-bit mode keeps 8..15
    run(0, 1, 8'h77, 0, 0, 0, 0, 0, 0, '0, 0);
    for (int i = 0; i < NR; i++) run(0, 1, 8'h10, 0, 1, 1, i, 0, 0, rnd256(), 0);
    // R8/R10: zero-all in 64-bit mode
    run(0, 1, 8'h77, 1, 1, 1, 0, 0, 0, '0, 0);
    for (int i = 0; i < 10; i++) run(1, 1, 8'h6F, 0, 1, 1, i, 0, 0, rnd256(), 1);
    // R8/R10: zero-all legacy range only
    run(0, 1, 8'h77, 0, 1, 0, 0, 0, 0, '0, 2);
    for (int i = 0; i < 4; i++) run(0, 1, 8'h28, 0, 1, 1, i, 0, 0, rnd256(), 0);
    // R2 narrow and wide moves
    run(0, 1, 8'h29, 1, 0, 1, 5, 1, 0, '0, 0);
    run(1, 1, 8'h7F, 1, 1, 1, 6, 2, 0, '0, 0);
    // R5 merge, R6 scalar load, R7 scalar store, R4 narrow store
    run(3, 1, 8'h11, 1, 1, 1, 7, 0, 9, '0, 0);
    run(3, 1, 8'h10, 0, 1, 1, 3, 0, 0, rnd256(), 3);
    run(3, 1, 8'h11, 0, 0, 1, 0, 7, 0, '0, 1);
    run(0, 1, 8'h11, 0, 0, 1, 0, 9, 0, '0, 0);
    // R11 illegal encodings
    run(2, 1, 8'h28, 1, 0, 1, 1, 2, 0, '0, 0);
    run(1, 2, 8'h28, 1, 0, 1, 1, 2, 0, '0, 0);
    run(0, 1, 8'h6F, 0, 0, 1, 1, 2, 0, '0, 0);
    run(1, 1, 8'h77, 0, 1, 1, 0, 0, 0, '0, 0);
    run(1, 1, 8'h28, 1, 1, 0, 9, 2, 0, '0, 0);
    run(3, 1, 8'h10, 1, 0, 0, 1, 2, 12, '0, 0);

    for (int n = 0; n < 600; n++) begin
      bit [1:0] p = 2'($urandom_range(0, 3));
      bit [1:0] m = ($urandom_range(0, 7) == 0) ? 2'($urandom_range(0, 3)) : 2'd1;
      bit [7:0] o = opcs[$urandom_range(0, 7)];
      if (o == 8'h00) o = 8'($urandom);
      if (o == 8'h77 && $urandom_range(0, 3) != 0) o = 8'h10;
      run(p, m, o, 1'($urandom), 1'($urandom), $urandom_range(0, 3) != 0,
          $urandom_range(0, 15), $urandom_range(0, 15), $urandom_range(0, 15),
          rnd256(), $urandom_range(0, 3));
    end

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end
endmodule